// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a 48-bit virtual address into a 40-bit physical address by reading translation descriptors from memory. It takes a request made of a virtual address, a table base address and a two-bit region-size setting. It then reads one 8-byte descriptor per level, up to three levels, over a read port that has one read in flight at a time. It returns either the physical address or a fault that names the level where the walk stopped.

The region-size setting chooses where the walk begins. With settings 0 and 1 the walk starts at level 1, and the level-1 index gets narrower as the setting rises. With setting 2 the walk starts at level 2. In that case the table base is first moved forward past four 4 KB tables. A block descriptor at level 1 or level 2 ends the walk early. The level-3 descriptor is always read as a page.

Requests use a valid/ready handshake. The response is a single-cycle pulse with no back-pressure. Memory reads use a valid/ready request and a separate response strobe that carries 64 bits of data.

Top module: `ptw_walker`

## Requirements
- R1: In the cycle after reset, `req_ready` is 1 and both `rsp_valid` and `mem_req_valid` are 0.
- R2: A walk that starts at level 1 uses split n = 5 - setting (setting 0 gives n = 5, setting 1 gives n = 4). The first read address is {base[39:n], VA[n+26:30], 3'b000}.
- R3: Setting 2 starts the walk at level 2 with n = 12. The first read address is {B[39:12], VA[29:21], 3'b000}, where B = base + 16384.
- R4: A table descriptor has bit0 = 1 and bit1 = 1 at level 1 or 2. Its bits [39:12] form the next table base. The next read is {desc[39:12], VA[29:21], 3'b000} after level 1, and {desc[39:12], VA[20:12], 3'b000} after level 2.
- R5: A block descriptor has bits [1:0] = 01. At level 1 it gives PA = {desc[39:30], VA[29:0]}, and at level 2 it gives PA = {desc[39:21], VA[20:0]}. No further read is made after a block.
- R6: A level-3 descriptor with bit0 = 1 is a page, whatever the value of bit1. It gives PA = {desc[39:12], VA[11:0]} with `rsp_fault` = 0.
- R7: A descriptor with bit0 = 0 ends the walk with `rsp_fault` = 1, `rsp_fault_lvl` set to its level (1, 2 or 3) and `rsp_pa` = 0.
- R8: Setting 3 faults with `rsp_fault_lvl` = 0 and no memory read, and the response comes in the cycle right after acceptance.
- R9: At most one read is in flight. `mem_req_addr` holds steady while a read waits for `mem_req_ready`. A walk makes exactly one read per level it visits, and never more than three.
- R10: `req_ready` is 0 from acceptance until the response has been given. A request held during a walk is not taken and does not change the result.
- R11: `rsp_valid` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken this cycle if valid |
| req_va | input | 48 | Virtual address to translate |
| req_base | input | 40 | Translation table base address |
| req_rsz | input | 2 | Region-size setting: 0/1 start at level 1, 2 starts at level 2, 3 is illegal |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_pa | output | 40 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_fault_lvl | output | 2 | Level of the faulting descriptor, 0 for an illegal setting |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | 40 | Byte address of the 8-byte descriptor |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Descriptor word |

## Verification
A wrong walk state shows up at the ports on the very next read. It appears as a read address built from the wrong VA slice or the wrong table base, or as a read count that does not match the descriptor chain, so each read address is compared as soon as it is issued. A lost or duplicated "read in flight" flag shows up within one cycle of a response, as a second outstanding read or a hung walk. A wrong level register shows up in the fault level or in the number of VA bits carried into a block address, so blocks and faults are exercised at every level and with both start points.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int unsigned VA_W        = 48;
    localparam int unsigned PA_W        = 40;
    localparam int unsigned DESC_W      = 64;
    localparam int unsigned SLOT_SH     = 3;
    localparam int unsigned PAGE_SH     = 12;
    localparam int unsigned L1_LSB      = 30;
    localparam int unsigned L2_LSB      = 21;
    localparam int unsigned L3_LSB      = 12;
    localparam int unsigned ROOT_BIAS   = 5;
    localparam int unsigned START2_BIAS = 14;
    localparam int unsigned SKIP_TABLES = 4;
    localparam int unsigned TABLE_BYTES = 1 << PAGE_SH;
    localparam int unsigned SPLIT_W     = 4;
    localparam int unsigned LSB_W       = 5;

    typedef logic [VA_W-1:0]    va_t;
    typedef logic [PA_W-1:0]    pa_t;
    typedef logic [SPLIT_W-1:0] split_t;

    localparam pa_t         START2_OFFSET = pa_t'(SKIP_TABLES * TABLE_BYTES);
    localparam logic [1:0]  RSZ_START2    = 2'd2;
    localparam logic [1:0]  RSZ_ILLEGAL   = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_L1,
        ST_FETCH_L2,
        ST_FETCH_L3,
        ST_DONE,
        ST_FAULT
    } walk_st_e;

    typedef enum logic [1:0] {
        DK_INVALID = 2'd0,
        DK_LEAF    = 2'd1,
        DK_TABLE   = 2'd2
    } desc_kind_e;

    typedef struct packed {
        desc_kind_e kind;
        pa_t        next_base;
        pa_t        leaf_pa;
    } desc_info_t;

    // Lowest VA bit that indexes the table at a given level.
    function automatic logic [LSB_W-1:0] level_lsb(input logic [1:0] lvl);
        case (lvl)
            2'd1:    return LSB_W'(L1_LSB);
            2'd2:    return LSB_W'(L2_LSB);
            default: return LSB_W'(L3_LSB);
        endcase
    endfunction

    function automatic pa_t low_mask(input logic [LSB_W-1:0] nbits);
        return (pa_t'(1) << nbits) - pa_t'(1);
    endfunction

endpackage

// File: rtl/ptw_slot_addr.sv
module ptw_slot_addr
    import ptw_pkg::*;
(
    input  pa_t        tbl_base,
    input  split_t     split,
    input  va_t        va,
    input  logic [1:0] lvl,
    output pa_t        slot_addr
);
    logic [LSB_W-1:0] idx_lsb;
    pa_t              idx_mask;
    pa_t              keep_mask;
    pa_t              idx;

    always_comb begin
        idx_lsb   = level_lsb(lvl);
        idx_mask  = low_mask(LSB_W'(split) - LSB_W'(SLOT_SH));
        keep_mask = ~low_mask(LSB_W'(split));
        idx       = pa_t'(va >> idx_lsb) & idx_mask;
        slot_addr = (tbl_base & keep_mask) | (idx << SLOT_SH);
    end
endmodule

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode
    import ptw_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    input  logic [1:0]        lvl,
    input  va_t               va,
    output desc_info_t        info
);
    pa_t  raw;
    pa_t  keep_va;
    logic unused_hi;

    assign raw       = desc[PA_W-1:0];
    assign unused_hi = ^desc[DESC_W-1:PA_W];

    always_comb begin
        keep_va        = low_mask(level_lsb(lvl));
        info.leaf_pa   = (raw & ~keep_va) | (pa_t'(va) & keep_va);
        info.next_base = raw & ~low_mask(LSB_W'(PAGE_SH));
        if (!desc[0])
            info.kind = DK_INVALID;
        else if (lvl == 2'd3)
            info.kind = DK_LEAF;
        else if (desc[1])
            info.kind = DK_TABLE;
        else
            info.kind = DK_LEAF;
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic [PA_W-1:0]   req_base,
    input  logic [1:0]        req_rsz,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              rsp_fault,
    output logic [1:0]        rsp_fault_lvl,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DESC_W-1:0] mem_rsp_data
);
    walk_st_e   st_q;
    logic       issued_q;
    pa_t        base_q;
    split_t     split_q;
    va_t        va_q;
    pa_t        pa_q;
    logic       fault_q;
    logic [1:0] flvl_q;

    logic       fetching;
    logic [1:0] cur_lvl;
    desc_info_t info;

    always_comb begin
        case (st_q)
            ST_FETCH_L1: cur_lvl = 2'd1;
            ST_FETCH_L2: cur_lvl = 2'd2;
            ST_FETCH_L3: cur_lvl = 2'd3;
            default:     cur_lvl = 2'd0;
        endcase
    end

    assign fetching = (cur_lvl != 2'd0);

    ptw_slot_addr u_slot (
        .tbl_base  (base_q),
        .split     (split_q),
        .va        (va_q),
        .lvl       (cur_lvl),
        .slot_addr (mem_req_addr)
    );

    ptw_desc_decode u_dec (
        .desc (mem_rsp_data),
        .lvl  (cur_lvl),
        .va   (va_q),
        .info (info)
    );

    assign req_ready     = (st_q == ST_IDLE);
    assign rsp_valid     = (st_q == ST_DONE) || (st_q == ST_FAULT);
    assign mem_req_valid = fetching && !issued_q;
    assign rsp_pa        = pa_q;
    assign rsp_fault     = fault_q;
    assign rsp_fault_lvl = flvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            issued_q <= 1'b0;
            base_q   <= '0;
            split_q  <= '0;
            va_q     <= '0;
            pa_q     <= '0;
            fault_q  <= 1'b0;
            flvl_q   <= 2'd0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q <= req_va;
                        if (req_rsz == RSZ_ILLEGAL) begin
                            st_q    <= ST_FAULT;
                            pa_q    <= '0;
                            fault_q <= 1'b1;
                            flvl_q  <= 2'd0;
                        end else if (req_rsz == RSZ_START2) begin
                            st_q    <= ST_FETCH_L2;
                            base_q  <= req_base + START2_OFFSET;
                            split_q <= SPLIT_W'(START2_BIAS) - {2'b00, req_rsz};
                        end else begin
                            st_q    <= ST_FETCH_L1;
                            base_q  <= req_base;
                            split_q <= SPLIT_W'(ROOT_BIAS) - {2'b00, req_rsz};
                        end
                    end
                end
                ST_FETCH_L1, ST_FETCH_L2, ST_FETCH_L3: begin
                    if (mem_req_valid && mem_req_ready)
                        issued_q <= 1'b1;
                    if (issued_q && mem_rsp_valid) begin
                        issued_q <= 1'b0;
                        case (info.kind)
                            DK_LEAF: begin
                                st_q    <= ST_DONE;
                                pa_q    <= info.leaf_pa;
                                fault_q <= 1'b0;
                                flvl_q  <= 2'd0;
                            end
                            DK_TABLE: begin
                                st_q    <= (st_q == ST_FETCH_L1) ? ST_FETCH_L2 : ST_FETCH_L3;
                                base_q  <= info.next_base;
                                split_q <= SPLIT_W'(PAGE_SH);
                            end
                            default: begin
                                st_q    <= ST_FAULT;
                                pa_q    <= '0;
                                fault_q <= 1'b1;
                                flvl_q  <= cur_lvl;
                            end
                        endcase
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic [1:0]  req_rsz,
    input logic        rsp_valid,
    input logic [39:0] rsp_pa,
    input logic        rsp_fault,
    input logic [1:0]  rsp_fault_lvl,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [39:0] mem_req_addr,
    input logic        mem_rsp_valid
);
    logic       busy;
    logic       pending;
    logic [2:0] reads;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            pending <= 1'b0;
            reads   <= '0;
        end else begin
            if (req_valid && req_ready) begin
                busy  <= 1'b1;
                reads <= '0;
            end else if (rsp_valid) begin
                busy <= 1'b0;
            end
            if (mem_req_valid && mem_req_ready) begin
                pending <= 1'b1;
                reads   <= reads + 3'd1;
            end else if (mem_rsp_valid) begin
                pending <= 1'b0;
            end
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (req_ready && !rsp_valid && !mem_req_valid));

    a_r7_fault_pa_zero: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_pa == 40'd0));

    a_r8_cfg_fault: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_rsz == 2'd3)
            |=> (rsp_valid && rsp_fault && rsp_fault_lvl == 2'd0));

    a_r8_no_read_cfg: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault && rsp_fault_lvl == 2'd0) |-> (reads == 3'd0));

    a_r9_one_outstanding: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !pending);

    a_r9_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r9_read_limit: assert property (@(posedge clk) disable iff (rst)
        busy |-> (reads <= 3'd3));

    a_r9_read_in_walk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> busy);

    a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        busy |-> !req_ready);

    a_r11_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    a_r11_rsp_needs_req: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> busy);
endmodule

bind ptw_walker ptw_walker_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_rsz       (req_rsz),
    .rsp_valid     (rsp_valid),
    .rsp_pa        (rsp_pa),
    .rsp_fault     (rsp_fault),
    .rsp_fault_lvl (rsp_fault_lvl),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_va = '0;
    logic [39:0] req_base = '0;
    logic [1:0]  req_rsz = '0;
    logic        rsp_valid;
    logic [39:0] rsp_pa;
    logic        rsp_fault;
    logic [1:0]  rsp_fault_lvl;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [39:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [63:0] mem_img [logic [39:0]];
    logic [39:0] fetch_log [$];

    always #4 clk = ~clk;

    ptw_walker u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_base(req_base), .req_rsz(req_rsz),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
        .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    // Memory model: two-cycle read latency, sampled and driven at negedge.
    initial begin
        int          lat = 0;
        logic [39:0] lat_addr = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (lat > 0) begin
                lat = lat - 1;
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_img.exists(lat_addr) ? mem_img[lat_addr] : 64'h0;
                end
            end else if (mem_req_valid && !rst) begin
                lat_addr = mem_req_addr;
                fetch_log.push_back(mem_req_addr);
                lat = 2;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [39:0] log_at(input int i);
        return (fetch_log.size() > i) ? fetch_log[i] : 40'hFF_FFFF_FFFF;
    endfunction

    task automatic run_walk(input logic [47:0] va, input logic [39:0] base,
                            input logic [1:0] rsz, output logic [39:0] pa,
                            output logic flt, output logic [1:0] lvl);
        int wait_cnt = 0;
        fetch_log.delete();
        @(negedge clk);
        req_va = va; req_base = base; req_rsz = rsz; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && wait_cnt < 200) begin
            @(negedge clk);
            wait_cnt++;
        end
        chk("R11 response arrives", {63'd0, rsp_valid}, 64'd1);
        pa = rsp_pa; flt = rsp_fault; lvl = rsp_fault_lvl;
        @(negedge clk);
        chk("R11 response lasts one cycle", {63'd0, rsp_valid}, 64'd0);
    endtask

    task automatic t_reset;
        chk("R1 req_ready after reset", {63'd0, req_ready}, 64'd1);
        chk("R1 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
        chk("R1 mem_req_valid after reset", {63'd0, mem_req_valid}, 64'd0);
    endtask

    task automatic t_full_walk;
        logic [47:0] va = 48'h0000_B2C5_6ABC;
        logic [39:0] base = 40'h00_8000_4018;
        logic [63:0] d1 = 64'h0000_0000_0012_3003;
        logic [63:0] d2 = 64'h0000_0000_0045_6003;
        logic [63:0] d3 = 64'hFFF0_00AB_CDE0_1003;
        logic [39:0] a1, a2, a3, pa;
        logic flt; logic [1:0] lvl;
        mem_img.delete();
        a1 = {base[39:5], va[31:30], 3'b000};
        a2 = {d1[39:12], va[29:21], 3'b000};
        a3 = {d2[39:12], va[20:12], 3'b000};
        mem_img[a1] = d1; mem_img[a2] = d2; mem_img[a3] = d3;
        run_walk(va, base, 2'd0, pa, flt, lvl);
        chk("R9 three reads", 64'(fetch_log.size()), 64'd3);
        chk("R2 level-1 address n=5", 64'(log_at(0)), 64'(a1));
        chk("R4 level-2 address from table", 64'(log_at(1)), 64'(a2));
        chk("R4 level-3 address from table", 64'(log_at(2)), 64'(a3));
        chk("R6 page address", 64'(pa), 64'({d3[39:12], va[11:0]}));
        chk("R6 no fault", {63'd0, flt}, 64'd0);
    endtask

    task automatic t_l1_block;
        logic [47:0] va = 48'h0000_4123_4567;
        logic [39:0] base = 40'h00_0100_0018;
        logic [63:0] d1 = 64'h0000_0055_4000_0001;
        logic [39:0] a1, pa;
        logic flt; logic [1:0] lvl;
        mem_img.delete();
        a1 = {base[39:4], va[30], 3'b000};
        mem_img[a1] = d1;
        run_walk(va, base, 2'd1, pa, flt, lvl);
        chk("R2 level-1 address n=4", 64'(log_at(0)), 64'(a1));
        chk("R5 level-1 block single read", 64'(fetch_log.size()), 64'd1);
        chk("R5 level-1 block address", 64'(pa), 64'({d1[39:30], va[29:0]}));
        chk("R5 level-1 block no fault", {63'd0, flt}, 64'd0);
    endtask

    task automatic t_l2_block;
        logic [47:0] va = 48'h0000_0A5F_FFFF;
        logic [39:0] base = 40'h00_0200_0000;
        logic [63:0] d1 = 64'h0000_0000_0077_7003;
        logic [63:0] d2 = 64'h0000_0033_33E0_0001;
        logic [39:0] a1, a2, pa;
        logic flt; logic [1:0] lvl;
        mem_img.delete();
        a1 = {base[39:5], va[31:30], 3'b000};
        a2 = {d1[39:12], va[29:21], 3'b000};
        mem_img[a1] = d1; mem_img[a2] = d2;
        run_walk(va, base, 2'd0, pa, flt, lvl);
        chk("R5 level-2 block two reads", 64'(fetch_log.size()), 64'd2);
        chk("R4 level-2 address", 64'(log_at(1)), 64'(a2));
        chk("R5 level-2 block address", 64'(pa), 64'({d2[39:21], va[20:0]}));
    endtask

    task automatic t_start_l2;
        logic [47:0] va = 48'h0000_C1A2_B3C4;
        logic [39:0] base = 40'h00_8000_3000;
        logic [63:0] d2 = 64'h0000_0000_0099_9003;
        logic [63:0] d3 = 64'h0000_000C_AFE0_0003;
        logic [39:0] adj, a2, a3, pa;
        logic flt; logic [1:0] lvl;
        mem_img.delete();
        adj = base + 40'd16384;
        a2 = {adj[39:12], va[29:21], 3'b000};
        a3 = {d2[39:12], va[20:12], 3'b000};
        mem_img[a2] = d2; mem_img[a3] = d3;
        run_walk(va, base, 2'd2, pa, flt, lvl);
        chk("R3 level-2 start first address", 64'(log_at(0)), 64'(a2));
        chk("R3 level-2 start two reads", 64'(fetch_log.size()), 64'd2);
        chk("R3 level-2 start page address", 64'(pa), 64'({d3[39:12], va[11:0]}));
    endtask

    task automatic t_faults;
        logic [47:0] va = 48'h0000_7654_3210;
        logic [39:0] base = 40'h00_0300_0000;
        logic [63:0] d1 = 64'h0000_0000_0011_1003;
        logic [63:0] d2 = 64'h0000_0000_0022_2003;
        logic [39:0] a1, a2, a3, pa;
        logic flt; logic [1:0] lvl;
        a1 = {base[39:5], va[31:30], 3'b000};
        a2 = {d1[39:12], va[29:21], 3'b000};
        a3 = {d2[39:12], va[20:12], 3'b000};
        // Level 1 invalid (bit0 = 0, bit1 = 1)
        mem_img.delete();
        mem_img[a1] = 64'h0000_0000_0011_1002;
        run_walk(va, base, 2'd0, pa, flt, lvl);
        chk("R7 level-1 fault flag", {63'd0, flt}, 64'd1);
        chk("R7 level-1 fault level", 64'(lvl), 64'd1);
        chk("R7 level-1 fault pa zero", 64'(pa), 64'd0);
        chk("R9 level-1 fault one read", 64'(fetch_log.size()), 64'd1);
        // Level 2 invalid (all zero)
        mem_img[a1] = d1;
        run_walk(va, base, 2'd0, pa, flt, lvl);
        chk("R7 level-2 fault level", 64'(lvl), 64'd2);
        chk("R7 level-2 fault flag", {63'd0, flt}, 64'd1);
        // Level 3 invalid
        mem_img[a2] = d2;
        run_walk(va, base, 2'd0, pa, flt, lvl);
        chk("R7 level-3 fault level", 64'(lvl), 64'd3);
        chk("R9 level-3 fault three reads", 64'(fetch_log.size()), 64'd3);
        // Level 3 with block encoding 01 is still a page
        mem_img[a3] = 64'h0000_0012_3456_7001;
        run_walk(va, base, 2'd0, pa, flt, lvl);
        chk("R6 level-3 01 is page", 64'(pa), 64'({28'h1234567, va[11:0]}));
        chk("R6 level-3 01 no fault", {63'd0, flt}, 64'd0);
    endtask

    task automatic t_cfg_fault;
        logic [39:0] pa; logic flt; logic [1:0] lvl;
        mem_img.delete();
        run_walk(48'h0000_1111_2222, 40'h00_4000_0000, 2'd3, pa, flt, lvl);
        chk("R8 setting 3 faults", {63'd0, flt}, 64'd1);
        chk("R8 setting 3 level 0", 64'(lvl), 64'd0);
        chk("R8 setting 3 no read", 64'(fetch_log.size()), 64'd0);
    endtask

    task automatic t_busy_ignore;
        logic [47:0] va = 48'h0000_B2C5_6ABC;
        logic [39:0] base = 40'h00_8000_4018;
        logic [63:0] d1 = 64'h0000_0000_0012_3003;
        logic [63:0] d2 = 64'h0000_0000_0045_6003;
        logic [63:0] d3 = 64'h0000_00AB_CDE0_1003;
        logic [39:0] a1, a2, a3;
        int  busy_ready = 0;
        int  wait_cnt = 0;
        mem_img.delete();
        a1 = {base[39:5], va[31:30], 3'b000};
        a2 = {d1[39:12], va[29:21], 3'b000};
        a3 = {d2[39:12], va[20:12], 3'b000};
        mem_img[a1] = d1; mem_img[a2] = d2; mem_img[a3] = d3;
        fetch_log.delete();
        @(negedge clk);
        req_va = va; req_base = base; req_rsz = 2'd0; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_va = 48'h0000_0000_0000_0FFF; req_rsz = 2'd1;
        while (!rsp_valid && wait_cnt < 200) begin
            if (req_ready) busy_ready++;
            @(negedge clk);
            wait_cnt++;
        end
        req_valid = 1'b0;
        chk("R10 req_ready low during walk", 64'(busy_ready), 64'd0);
        chk("R10 result of first request", 64'(rsp_pa), 64'({d3[39:12], va[11:0]}));
        repeat (3) @(negedge clk);
        chk("R10 held request not taken", 64'(fetch_log.size()), 64'd3);
        chk("R10 idle after walk", {63'd0, req_ready}, 64'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_full_walk();
        t_l1_block();
        t_l2_block();
        t_start_l2();
        t_faults();
        t_cfg_fault();
        t_busy_ignore();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule